// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block keeps an asynchronous DRAM's contents alive. After reset it first waits out a power-up pause with every strobe idle. It then runs a fixed number of wake-up refresh cycles, and only after those does it declare the memory ready. From then on an interval timer adds one owed refresh at a steady rate, so the whole row space is covered within the retention period. The block asks an access controller for the bus with `req` and drives the row and column strobes itself once `gnt` comes back. The grant must be held until `bus_own` drops, which covers the whole cycle including row precharge.

Each refresh cycle takes one of two shapes, chosen by `row_only`. In the first, the column strobes fall ahead of the row strobe and the device supplies the row address itself. In the second, the row strobe falls on an address taken from the block's own row counter while both column strobes stay high. Owed refreshes build up in a small saturating backlog, so a long page burst can hold off refresh without losing any of it. When the backlog is full, `urgent` tells the controller to close its page at once. If the strobes stay quiet for too long, the wake-up sequence is run again. An optional self-refresh mode holds the device in an internal refresh state for as long as `self_req` stays high.

Top module: `dram_refresh_sched`

## Requirements
- R1: For PWRUP_CYC cycles after reset, `ras_n` is 1, `cas_n` is 2'b11, and `req` and `ready` are 0.
- R2: After the pause, INIT_CYCLES refresh cycles of the selected shape are run while `ready` is 0. `ready` rises on the clock that ends the last of them.
- R3: In a column-first cycle, `cas_n` is 2'b00 for CAS_SU_CYC cycles before `ras_n` falls. It stays 2'b00 for the first CAS_HOLD_CYC of the RAS_LOW_CYC cycles that `ras_n` is low, and RP_CYC cycles of precharge follow. `we_n` is 1 at all times.
- R4: In a row-only cycle, `cas_n` stays 2'b11 while `ras_n` is low for RAS_LOW_CYC cycles, and `row_addr` shows the row counter. The counter steps by one after each row-only cycle and wraps from all ones to zero. Column-first cycles leave it unchanged.
- R5: While `ready` is 1, one refresh is owed every INTERVAL_CYC cycles. `req` is 1 while any refresh is owed. Each completed cycle clears one owed refresh, and `req` returns to 0 once all are served.
- R6: The count of owed refreshes saturates at PEND_MAX, and further interval events are dropped. `urgent` is 1 exactly while the count sits at PEND_MAX.
- R7: A cycle starts only on a clock with `gnt` and `req` both 1 and no cycle running. `bus_own` stays 1 from that clock through the last precharge cycle, and no strobe moves while `bus_own` is 0.
- R8: If IDLE_LIMIT_CYC consecutive cycles pass while `ready` is 1 with neither `ext_act` high nor `ras_n` low, `ready` drops and INIT_CYCLES cycles are run again. `ext_act` pulses spaced closer than that keep `ready` at 1.
- R9: If `self_req` is 1 when a cycle starts with `ready` at 1, a self-refresh cycle runs. In it, `cas_n` is 2'b00 for CAS_SU_CYC cycles before `ras_n` falls. `ras_n` then stays low for at least SELF_RAS_CYC cycles and until `self_req` is seen low, with `cas_n` at 2'b00 throughout. SELF_PRE_CYC cycles of precharge follow.
- R10: Self refresh takes precedence over owed refreshes, and the end of a self-refresh cycle clears the whole backlog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_only | input | 1 | 1 selects row-only cycles, 0 selects column-first cycles |
| self_req | input | 1 | Request and hold self refresh |
| gnt | input | 1 | Bus grant from the access controller |
| ext_act | input | 1 | One-cycle pulse for each strobe cycle run by the access controller |
| req | output | 1 | Bus request |
| urgent | output | 1 | Backlog full, close the open page now |
| ready | output | 1 | Initialization done, normal accesses allowed |
| bus_own | output | 1 | Block drives the strobes this cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Column strobes, upper and lower byte, active low |
| we_n | output | 1 | Write enable, held high |
| row_addr | output | ROW_BITS | Row address for row-only cycles |

## Verification
The assertions assume that the access controller keeps `gnt` high for as long as `bus_own` is 1, and that it only starts its own strobe activity while the block does not own the bus. The bench meets both conditions by building `gnt` from the request and ownership outputs under a single enable. It drops that enable only between cycles, never while one is running. `self_req` is raised only while no cycle is in flight and dropped only while the row strobe is already low. Mode changes are made only in idle gaps, so each cycle's shape is fixed at its start.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_CBR_SU,
    SQ_CBR_RAS,
    SQ_ROW_RAS,
    SQ_PRE,
    SQ_SELF_SU,
    SQ_SELF_RAS
  } sq_state_t;

  typedef enum logic [1:0] {
    KIND_CBR,
    KIND_ROW,
    KIND_SELF
  } rf_kind_t;

  typedef enum logic [1:0] {
    PH_PWRUP,
    PH_INIT,
    PH_RUN
  } phase_t;

  // bits needed to hold the value n
  function automatic int unsigned bits_for(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // backlog arithmetic: clear wins, then remove one served, then add one owed
  function automatic int unsigned backlog_next(input int unsigned cur, input bit add,
                                               input bit sub, input bit clr,
                                               input int unsigned lim);
    int unsigned n;
    if (clr) return 0;
    n = cur;
    if (sub && n > 0) n = n - 1;
    if (add && n < lim) n = n + 1;
    return n;
  endfunction

endpackage

// File: rtl/dram_refresh_tick.sv
module dram_refresh_tick
  import dram_refresh_pkg::*;
#(
  parameter int unsigned PERIOD = 3900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = bits_for(PERIOD);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == CW'(PERIOD - 1));
  assign tick    = run && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (at_last) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R5
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/dram_refresh_backlog.sv
module dram_refresh_backlog
  import dram_refresh_pkg::*;
#(
  parameter int unsigned LIMIT = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       add,
  input  logic                       sub,
  input  logic                       clr,
  output logic [bits_for(LIMIT)-1:0] level,
  output logic                       full,
  output logic                       any
);
  localparam int unsigned PW = bits_for(LIMIT);

  logic [PW-1:0] level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= PW'(backlog_next(32'(level_q), add, sub, clr, LIMIT));
  end

  assign level = level_q;
  assign full  = (level_q == PW'(LIMIT));
  assign any   = (level_q != '0);

  // R6
  backlog_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && add && !sub && !clr) |=> full);

  // R5
  backlog_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub && !add && !clr && any) |=> (level == $past(level) - 1'b1));

endmodule

// File: rtl/dram_refresh_strobe.sv
module dram_refresh_strobe
  import dram_refresh_pkg::*;
#(
  parameter int unsigned CAS_SU_CYC   = 2,
  parameter int unsigned CAS_HOLD_CYC = 3,
  parameter int unsigned RAS_LOW_CYC  = 15,
  parameter int unsigned RP_CYC       = 10,
  parameter int unsigned SELF_RAS_CYC = 25000,
  parameter int unsigned SELF_PRE_CYC = 27,
  parameter int unsigned ROW_BITS     = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  rf_kind_t            kind_in,
  input  logic                self_hold,
  output logic                busy,
  output logic                done,
  output rf_kind_t            cur_kind,
  output logic                ras_n,
  output logic [1:0]          cas_n,
  output logic [ROW_BITS-1:0] row_addr
);
  localparam int unsigned CMAX =
    max2(max2(max2(CAS_SU_CYC, RAS_LOW_CYC), max2(RP_CYC, SELF_RAS_CYC)), SELF_PRE_CYC);
  localparam int unsigned CW         = bits_for(CMAX);
  localparam int unsigned HOLD_FLOOR = RAS_LOW_CYC - CAS_HOLD_CYC;

  sq_state_t           st_q;
  logic [CW-1:0]       cnt_q;
  rf_kind_t            kind_q;
  logic [ROW_BITS-1:0] row_q;

  logic cnt_zero, ras_low, cas_low, row_step;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      kind_q <= KIND_CBR;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (start) begin
          kind_q <= kind_in;
          unique case (kind_in)
            KIND_ROW:  begin st_q <= SQ_ROW_RAS; cnt_q <= CW'(RAS_LOW_CYC - 1); end
            KIND_SELF: begin st_q <= SQ_SELF_SU; cnt_q <= CW'(CAS_SU_CYC - 1);  end
            default:   begin st_q <= SQ_CBR_SU;  cnt_q <= CW'(CAS_SU_CYC - 1);  end
          endcase
        end
        SQ_CBR_SU:
          if (cnt_zero) begin st_q <= SQ_CBR_RAS; cnt_q <= CW'(RAS_LOW_CYC - 1); end
          else cnt_q <= cnt_q - 1'b1;
        SQ_SELF_SU:
          if (cnt_zero) begin st_q <= SQ_SELF_RAS; cnt_q <= CW'(SELF_RAS_CYC - 1); end
          else cnt_q <= cnt_q - 1'b1;
        SQ_CBR_RAS, SQ_ROW_RAS:
          if (cnt_zero) begin st_q <= SQ_PRE; cnt_q <= CW'(RP_CYC - 1); end
          else cnt_q <= cnt_q - 1'b1;
        SQ_SELF_RAS:
          if (!cnt_zero) cnt_q <= cnt_q - 1'b1;
          else if (!self_hold) begin st_q <= SQ_PRE; cnt_q <= CW'(SELF_PRE_CYC - 1); end
        SQ_PRE:
          if (cnt_zero) st_q <= SQ_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign ras_low  = (st_q == SQ_CBR_RAS) || (st_q == SQ_ROW_RAS) || (st_q == SQ_SELF_RAS);
  assign cas_low  = (st_q == SQ_CBR_SU) || (st_q == SQ_SELF_SU) || (st_q == SQ_SELF_RAS) ||
                    ((st_q == SQ_CBR_RAS) && (cnt_q >= CW'(HOLD_FLOOR)));
  assign busy     = (st_q != SQ_IDLE);
  assign done     = (st_q == SQ_PRE) && cnt_zero;
  assign row_step = done && (kind_q == KIND_ROW);

  always_ff @(posedge clk) begin
    if (!rst_n)        row_q <= '0;
    else if (row_step) row_q <= row_q + 1'b1;
  end

  assign ras_n    = !ras_low;
  assign cas_n    = {2{!cas_low}};
  assign cur_kind = kind_q;
  assign row_addr = row_q;

  // checker-only run length of the row strobe, saturating at the self minimum
  localparam int unsigned LW = bits_for(SELF_RAS_CYC);
  logic [LW-1:0] low_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n || ras_n)                   low_run_q <= '0;
    else if (low_run_q < LW'(SELF_RAS_CYC)) low_run_q <= low_run_q + 1'b1;
  end

  // R3
  cbr_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && kind_q != KIND_ROW) |-> ($past(cas_n) != 2'b11));

  // R4
  row_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && kind_q == KIND_ROW) |-> (cas_n == 2'b11));

  // R4
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_step |=> (row_addr == $past(row_addr) + 1'b1));

  // R7
  ras_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || cas_n != 2'b11) |-> busy);

  // R9
  self_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n) && kind_q == KIND_SELF) |-> (low_run_q >= LW'(SELF_RAS_CYC)));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_refresh_pkg::*;
#(
  parameter int unsigned PWRUP_CYC      = 50000,
  parameter int unsigned INTERVAL_CYC   = 3900,
  parameter int unsigned IDLE_LIMIT_CYC = 2000000,
  parameter int unsigned INIT_CYCLES    = 8,
  parameter int unsigned PEND_MAX       = 7,
  parameter int unsigned CAS_SU_CYC     = 2,
  parameter int unsigned CAS_HOLD_CYC   = 3,
  parameter int unsigned RAS_LOW_CYC    = 15,
  parameter int unsigned RP_CYC         = 10,
  parameter int unsigned SELF_RAS_CYC   = 25000,
  parameter int unsigned SELF_PRE_CYC   = 27,
  parameter int unsigned ROW_BITS       = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                row_only,
  input  logic                self_req,
  input  logic                gnt,
  input  logic                ext_act,
  output logic                req,
  output logic                urgent,
  output logic                ready,
  output logic                bus_own,
  output logic                ras_n,
  output logic [1:0]          cas_n,
  output logic                we_n,
  output logic [ROW_BITS-1:0] row_addr
);
  localparam int unsigned PWW = bits_for(PWRUP_CYC);
  localparam int unsigned INW = bits_for(INIT_CYCLES);
  localparam int unsigned IDW = bits_for(IDLE_LIMIT_CYC);
  localparam int unsigned PW  = bits_for(PEND_MAX);

  phase_t         phase_q;
  logic [PWW-1:0] pw_q;
  logic [INW-1:0] init_left_q;
  logic [IDW-1:0] idle_q;

  logic     tick, seq_busy, seq_done, seq_start, pend_any, pend_full;
  logic     strobe_act, idle_hit, self_done;
  rf_kind_t kind_sel, seq_kind;
  logic [PW-1:0] pend_level;

  assign ready      = (phase_q == PH_RUN);
  assign req        = (phase_q == PH_INIT) || (ready && (pend_any || self_req));
  assign seq_start  = gnt && req && !seq_busy;
  assign kind_sel   = (ready && self_req) ? KIND_SELF : (row_only ? KIND_ROW : KIND_CBR);
  assign strobe_act = ext_act || !ras_n;
  assign idle_hit   = ready && !strobe_act && (idle_q == IDW'(IDLE_LIMIT_CYC - 1));
  assign self_done  = seq_done && (seq_kind == KIND_SELF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_PWRUP;
      pw_q        <= '0;
      init_left_q <= '0;
    end else begin
      unique case (phase_q)
        PH_PWRUP:
          if (pw_q == PWW'(PWRUP_CYC - 1)) begin
            phase_q     <= PH_INIT;
            init_left_q <= INW'(INIT_CYCLES);
          end else pw_q <= pw_q + 1'b1;
        PH_INIT:
          if (seq_done) begin
            init_left_q <= init_left_q - 1'b1;
            if (init_left_q == INW'(1)) phase_q <= PH_RUN;
          end
        PH_RUN:
          if (idle_hit) begin
            phase_q     <= PH_INIT;
            init_left_q <= INW'(INIT_CYCLES);
          end
        default: phase_q <= PH_PWRUP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !ready || strobe_act || idle_hit) idle_q <= '0;
    else                                            idle_q <= idle_q + 1'b1;
  end

  dram_refresh_tick #(.PERIOD(INTERVAL_CYC)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (ready),
    .tick (tick)
  );

  dram_refresh_backlog #(.LIMIT(PEND_MAX)) u_backlog (
    .clk  (clk),
    .rst_n(rst_n),
    .add  (tick),
    .sub  (seq_done && ready && (seq_kind != KIND_SELF)),
    .clr  (self_done),
    .level(pend_level),
    .full (pend_full),
    .any  (pend_any)
  );

  dram_refresh_strobe #(
    .CAS_SU_CYC  (CAS_SU_CYC),
    .CAS_HOLD_CYC(CAS_HOLD_CYC),
    .RAS_LOW_CYC (RAS_LOW_CYC),
    .RP_CYC      (RP_CYC),
    .SELF_RAS_CYC(SELF_RAS_CYC),
    .SELF_PRE_CYC(SELF_PRE_CYC),
    .ROW_BITS    (ROW_BITS)
  ) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (seq_start),
    .kind_in  (kind_sel),
    .self_hold(self_req),
    .busy     (seq_busy),
    .done     (seq_done),
    .cur_kind (seq_kind),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .row_addr (row_addr)
  );

  assign urgent  = pend_full;
  assign bus_own = seq_busy;
  assign we_n    = 1'b1;

  // R1
  pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PWRUP) |-> (ras_n && cas_n == 2'b11 && !req && !ready));

  // R2
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(seq_done));

  // R6
  urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |-> req);

  // R7
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own |-> gnt);

  // R8
  idle_reinit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(idle_hit));

  // R10
  self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    self_done |=> (pend_level == '0));

endmodule

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;

  localparam int PWRUP = 200, INTV = 150, IDLE = 1000, NINIT = 8, PMAX = 3;
  localparam int SU = 2, HOLD = 3, RASW = 6, RP = 4, SRAS = 30, SPRE = 5, RB = 4;
  localparam int K_CBR = 0, K_ROW = 1, K_SELF = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, row_only, self_req, ext_act, gnt, gnt_en;
  logic req, urgent, ready, bus_own, ras_n, we_n;
  logic [1:0] cas_n;
  logic [RB-1:0] row_addr;

  assign gnt = gnt_en && (req || bus_own);

  dram_refresh_sched #(
    .PWRUP_CYC(PWRUP), .INTERVAL_CYC(INTV), .IDLE_LIMIT_CYC(IDLE), .INIT_CYCLES(NINIT),
    .PEND_MAX(PMAX), .CAS_SU_CYC(SU), .CAS_HOLD_CYC(HOLD), .RAS_LOW_CYC(RASW),
    .RP_CYC(RP), .SELF_RAS_CYC(SRAS), .SELF_PRE_CYC(SPRE), .ROW_BITS(RB)
  ) u_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .row_only(row_only), .self_req(self_req), .gnt(gnt),
    .ext_act(ext_act), .req(req), .urgent(urgent), .ready(ready), .bus_own(bus_own),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row_addr(row_addr)
  );

  typedef struct {
    int    kind, lead, rasw, hold, pre, addr;
    string tag;
  } rec_t;

  rec_t exp_q[$];
  int n_checks = 0, n_fail = 0;
  int rec_cnt = 0, init_recs = 0, we_bad = 0, exp_row = 0;

  task automatic chk(string tag, int act, int exp, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push(int kind, int rasw, string tag);
    rec_t e;
    e.kind = kind; e.tag = tag; e.rasw = rasw;
    e.lead = (kind == K_ROW) ? 0 : SU;
    e.hold = (kind == K_ROW) ? 0 : ((kind == K_SELF) ? rasw : HOLD);
    e.pre  = (kind == K_SELF) ? SPRE : RP;
    e.addr = -1;
    if (kind == K_ROW) begin
      e.addr = exp_row % (1 << RB);
      exp_row++;
    end
    exp_q.push_back(e);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_recs(int target);
    while (rec_cnt < target) @(negedge clk);
  endtask

  // monitor: measures each owned-bus episode and compares with the queue
  int  m_lead, m_rasw, m_hold, m_pre, m_addr;
  bit  in_rec, m_seen, m_ready;
  always @(negedge clk) begin
    if (rst_n) begin
      if (we_n !== 1'b1) we_bad++;
      if (bus_own) begin
        if (!in_rec) begin
          in_rec = 1; m_seen = 0; m_lead = 0; m_rasw = 0; m_hold = 0; m_pre = 0; m_addr = -1;
        end
        if (!ras_n) begin
          if (!m_seen) begin m_seen = 1; m_addr = int'(row_addr); m_ready = ready; end
          m_rasw++;
          if (cas_n != 2'b11) m_hold++;
        end else if (!m_seen) begin
          if (cas_n == 2'b00) m_lead++;
        end else m_pre++;
      end else if (in_rec) begin
        rec_t e;
        int   kind;
        in_rec = 0;
        rec_cnt++;
        if (!m_ready) init_recs++;
        kind = (m_lead == 0) ? K_ROW : ((m_rasw >= SRAS) ? K_SELF : K_CBR);
        n_checks++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R7 unexpected cycle actual=kind%0d expected=none", kind);
        end else begin
          e = exp_q.pop_front();
          if (kind != e.kind || m_lead != e.lead || m_rasw != e.rasw || m_hold != e.hold ||
              m_pre != e.pre || (e.addr >= 0 && m_addr != e.addr)) begin
            n_fail++;
            $display("FAIL %s cycle actual=k%0d/lead%0d/ras%0d/hold%0d/pre%0d/a%0d expected=k%0d/lead%0d/ras%0d/hold%0d/pre%0d/a%0d",
                     e.tag, kind, m_lead, m_rasw, m_hold, m_pre, m_addr,
                     e.kind, e.lead, e.rasw, e.hold, e.pre, e.addr);
          end
        end
      end
    end
  end

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog run incomplete actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    int base;
    rst_n = 0; row_only = 0; self_req = 0; ext_act = 0; gnt_en = 1;
    cyc(5);
    rst_n = 1;
    // R1: quiet pause
    cyc(10);
    chk("R1", int'(ras_n), 1, "ras_n in pause");
    chk("R1", int'(cas_n), 3, "cas_n in pause");
    chk("R1", int'(req), 0, "req in pause");
    cyc(180);
    chk("R1", int'(ready), 0, "ready late in pause");
    chk("R1", int'(req), 0, "req late in pause");
    // R2: wake-up cycles, column-first shape (R3)
    for (int i = 0; i < NINIT; i++) push(K_CBR, RASW, "R3");
    wait_recs(NINIT);
    chk("R2", init_recs, NINIT, "wake-up cycle count");
    chk("R2", int'(ready), 1, "ready after wake-up");
    // R5: steady interval refresh
    for (int i = 0; i < 3; i++) push(K_CBR, RASW, "R5");
    wait_recs(NINIT + 3);
    cyc(1);
    chk("R5", int'(req), 0, "req after serving");
    // R4: row-only with counter wrap
    row_only = 1;
    for (int i = 0; i < 18; i++) push(K_ROW, RASW, "R4");
    wait_recs(NINIT + 21);
    // R6/R7: withheld grant, backlog saturation
    gnt_en = 0;
    base = rec_cnt;
    cyc(300);
    chk("R6", int'(urgent), 0, "urgent at two owed");
    chk("R5", int'(req), 1, "req with owed refresh");
    cyc(150);
    chk("R6", int'(urgent), 1, "urgent at limit");
    cyc(150);
    chk("R6", int'(urgent), 1, "urgent past limit");
    chk("R7", rec_cnt, base, "no cycle without grant");
    for (int i = 0; i < PMAX; i++) push(K_ROW, RASW, "R6");
    gnt_en = 1;
    wait_recs(base + PMAX);
    cyc(1);
    chk("R6", int'(req), 0, "extra owed refresh dropped");
    chk("R6", int'(urgent), 0, "urgent after drain");
    // R8: external activity keeps ready, silence forces re-init
    gnt_en = 0;
    for (int k = 0; k < 4; k++) begin
      cyc(299); ext_act = 1; cyc(1); ext_act = 0;
    end
    chk("R8", int'(ready), 1, "ready kept by activity");
    cyc(1100);
    chk("R8", int'(ready), 0, "ready after silence");
    chk("R8", int'(req), 1, "req for re-init");
    base = init_recs;
    for (int i = 0; i < NINIT + PMAX; i++) push(K_ROW, RASW, "R8");
    gnt_en = 1;
    wait_recs(rec_cnt + NINIT + PMAX);
    chk("R8", init_recs - base, NINIT, "re-init cycle count");
    // R9/R10: long self refresh with owed refreshes pending
    gnt_en = 0; self_req = 1;
    cyc(310);
    push(K_SELF, 51, "R9");
    base = rec_cnt;
    gnt_en = 1;
    while (ras_n) @(negedge clk);
    cyc(50);
    self_req = 0;
    wait_recs(base + 1);
    chk("R10", int'(req), 0, "backlog cleared by self refresh");
    // R9: minimum self width
    self_req = 1;
    push(K_SELF, SRAS, "R9");
    @(negedge clk);
    while (ras_n) @(negedge clk);
    self_req = 0;
    wait_recs(base + 2);
    chk("R3", we_bad, 0, "we_n low samples");
    chk("R7", exp_q.size(), 0, "expected cycles left");
    summary();
    $finish;
  end

endmodule